// File: doc/BRIEF.md
# Serial Clock Pulse Count Guard

This block sits beside the front end of a serial, three-wire EEPROM-style command port. It guards against spurious or missing serial clock edges. While chip select is high it waits for the start bit, which is the first serial clock rising edge that samples the data line at 1. From that edge on it counts every serial clock rising edge. It also captures the opcode and sub-opcode bits that follow the start bit. When chip select falls, it checks the count against the exact frame length of the decoded modifying command, for the organisation latched at the start bit. It then issues either a one-cycle permit pulse or a one-cycle reject pulse.

The programming sequencer launches a write or erase only when it sees the permit pulse. One added or dropped clock pulse shifts the address and data by one bit, so such a frame is cancelled. Reads and the enable/disable commands never produce a pulse. The serial lines are taken as already synchronised to the system clock, and edges are found by comparing each sample with the one before.

Top module: `sclk_count_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, `permit_o` and `reject_o` are 0 and `cmd_o` is 2'b00.
- R2: Serial clock rising edges that sample the data line at 0 while chip select is high, before the first 1, are not counted. The edge that samples the first 1 counts as pulse 1.
- R3: A WRITE (opcode bits 0 then 1 after the start bit) in byte mode (`org_i`=0 at the start bit) is permitted only with exactly 20 pulses: start, 2 opcode, 9 address, 8 data. `cmd_o`=2'b00 with the pulse.
- R4: A WRITE in word mode (`org_i`=1 at the start bit) is permitted only with exactly 27 pulses: start, 2 opcode, 8 address, 16 data.
- R5: ERASE (opcode 1,1; `cmd_o`=2'b01) and ERASE-ALL (opcode 0,0 then sub-bits 1,0; `cmd_o`=2'b10) are permitted only with 12 pulses in byte mode and 11 pulses in word mode.
- R6: WRITE-ALL (opcode 0,0 then sub-bits 0,1; `cmd_o`=2'b11) uses the same lengths as WRITE: 20 in byte mode, 27 in word mode.
- R7: A modifying command whose count differs from its length by any amount gives `reject_o` and no `permit_o`. `cmd_o` still names the command.
- R8: READ (opcode 1,0), the enable and disable commands (opcode 0,0 with sub-bits 1,1 or 0,0), and frames that end before their opcode or sub-bits are complete give neither pulse.
- R9: The pulse counter saturates instead of wrapping. A frame whose length exceeds the expected length by a multiple of the counter range is still rejected.
- R10: `permit_o` and `reject_o` are never high together. Each lasts one cycle and appears in the cycle after the first sample of chip select low. `cmd_o` is 2'b00 whenever neither is high.
- R11: Serial clock edges while chip select is low are ignored. Changing `org_i` after the start bit does not change the expected length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, synchronised, active high |
| sck_i | input | 1 | Serial clock, synchronised sample |
| sdi_i | input | 1 | Serial data in, synchronised sample |
| org_i | input | 1 | Organisation: 1 = word, 0 = byte; latched at start bit |
| permit_o | output | 1 | One-cycle pulse: modifying command may execute |
| reject_o | output | 1 | One-cycle pulse: modifying command cancelled |
| cmd_o | output | 2 | Command code carried with a pulse, otherwise 0 |

## Verification
Every modifying command is sent at its exact length in both organisations. Each must permit, which shows that the length table is right for each opcode and mode. The same frames are then sent one pulse long and one pulse short, and must reject, which shows that the comparison is exact rather than a bound. Read, enable and disable frames and truncated headers must stay silent, which separates modifying from non-modifying decode. Leading zeros, clocks while deselected, a mid-frame organisation change, and a burst longer than the counter range test the start detection, the latch of the organisation and saturation against wrap-around.

// File: rtl/sclk_guard_pkg.sv
package sclk_guard_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_ERASE = 2'b01,
    CMD_ERAL  = 2'b10,
    CMD_WRAL  = 2'b11
  } guard_cmd_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/sclk_sat_counter.sv
module sclk_sat_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr_i)                   cnt_o <= '0;
    else if (load_i)                    cnt_o <= CNT_W'(1);
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sclk_len_table.sv
module sclk_len_table
  import sclk_guard_pkg::*;
#(
  parameter int WORD_ADDR_W = 8,
  parameter int BYTE_DATA_W = 8,
  parameter int WORD_DATA_W = 16,
  parameter int CNT_W       = 6
) (
  input  logic [1:0]       op_i,
  input  logic [1:0]       sub_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             org_word_i,
  output logic             is_mod_o,
  output guard_cmd_e       cmd_o,
  output logic [CNT_W-1:0] exp_len_o
);
  localparam int HDR_LEN     = 3;
  localparam int SUB_LEN     = 5;
  localparam int BYTE_ADDR_W = WORD_ADDR_W + 1;
  localparam int ERASE_B     = HDR_LEN + BYTE_ADDR_W;
  localparam int ERASE_W     = HDR_LEN + WORD_ADDR_W;
  localparam int WRITE_B     = ERASE_B + BYTE_DATA_W;
  localparam int WRITE_W     = ERASE_W + WORD_DATA_W;

  logic has_data;

  always_comb begin
    is_mod_o = 1'b0;
    cmd_o    = CMD_WRITE;
    has_data = 1'b0;
    if (int'(cnt_i) >= HDR_LEN) begin
      unique case (op_i)
        OP_WRITE: begin is_mod_o = 1'b1; cmd_o = CMD_WRITE; has_data = 1'b1; end
        OP_ERASE: begin is_mod_o = 1'b1; cmd_o = CMD_ERASE; end
        OP_EXT: begin
          if (int'(cnt_i) >= SUB_LEN) begin
            if (sub_i == SUB_ERAL) begin
              is_mod_o = 1'b1; cmd_o = CMD_ERAL;
            end else if (sub_i == SUB_WRAL) begin
              is_mod_o = 1'b1; cmd_o = CMD_WRAL; has_data = 1'b1;
            end
          end
        end
        default: is_mod_o = 1'b0;
      endcase
    end
    if (has_data) exp_len_o = org_word_i ? CNT_W'(WRITE_W) : CNT_W'(WRITE_B);
    else          exp_len_o = org_word_i ? CNT_W'(ERASE_W) : CNT_W'(ERASE_B);
  end
endmodule

// File: rtl/sclk_count_guard.sv
module sclk_count_guard
  import sclk_guard_pkg::*;
#(
  parameter int WORD_ADDR_W = 8,
  parameter int BYTE_DATA_W = 8,
  parameter int WORD_DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       org_i,
  output logic       permit_o,
  output logic       reject_o,
  output logic [1:0] cmd_o
);
  localparam int MAX_LEN = 3 + WORD_ADDR_W + 1 +
                           ((WORD_DATA_W > BYTE_DATA_W) ? WORD_DATA_W : BYTE_DATA_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;

  logic             sck_rise, sck_fall_unused;
  logic             cs_rise_unused, cs_fall;
  logic [CNT_W-1:0] cnt;
  logic             start_hit, bit_hit;
  logic [1:0]       op_q, sub_q;
  logic             org_q;
  logic             is_mod;
  guard_cmd_e       cmd_dec;
  logic [CNT_W-1:0] exp_len;

  sclk_edge_det u_sck_edge (
    .clk(clk), .rst(rst), .sig_i(sck_i),
    .rise_o(sck_rise), .fall_o(sck_fall_unused)
  );

  sclk_edge_det u_cs_edge (
    .clk(clk), .rst(rst), .sig_i(cs_i),
    .rise_o(cs_rise_unused), .fall_o(cs_fall)
  );

  assign start_hit = cs_i && sck_rise && (cnt == '0) && sdi_i;
  assign bit_hit   = cs_i && sck_rise && (cnt != '0);

  sclk_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(~cs_i),
    .load_i(start_hit), .inc_i(bit_hit), .cnt_o(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || !cs_i) begin
      op_q  <= 2'b00;
      sub_q <= 2'b00;
      org_q <= 1'b0;
    end else begin
      if (start_hit) org_q <= org_i;
      if (bit_hit) begin
        case (int'(cnt))
          1: op_q[1]  <= sdi_i;
          2: op_q[0]  <= sdi_i;
          3: sub_q[1] <= sdi_i;
          4: sub_q[0] <= sdi_i;
          default: ;
        endcase
      end
    end
  end

  sclk_len_table #(
    .WORD_ADDR_W(WORD_ADDR_W), .BYTE_DATA_W(BYTE_DATA_W),
    .WORD_DATA_W(WORD_DATA_W), .CNT_W(CNT_W)
  ) u_len (
    .op_i(op_q), .sub_i(sub_q), .cnt_i(cnt), .org_word_i(org_q),
    .is_mod_o(is_mod), .cmd_o(cmd_dec), .exp_len_o(exp_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      permit_o <= 1'b0;
      reject_o <= 1'b0;
      cmd_o    <= 2'b00;
    end else if (cs_fall && is_mod) begin
      permit_o <= (cnt == exp_len);
      reject_o <= (cnt != exp_len);
      cmd_o    <= cmd_dec;
    end else begin
      permit_o <= 1'b0;
      reject_o <= 1'b0;
      cmd_o    <= 2'b00;
    end
  end
endmodule

// File: rtl/sclk_count_guard_chk.sv
module sclk_count_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_i,
  input logic       permit_o,
  input logic       reject_o,
  input logic [1:0] cmd_o
);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(permit_o && reject_o));

  p_permit_single_r10: assert property (@(posedge clk) disable iff (rst)
    permit_o |=> !permit_o);

  p_reject_single_r10: assert property (@(posedge clk) disable iff (rst)
    reject_o |=> !reject_o);

  p_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (permit_o || reject_o) |-> ($past(cs_i, 2) && !$past(cs_i, 1)));

  p_cmd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !(permit_o || reject_o) |-> (cmd_o == 2'b00));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!permit_o && !reject_o));
endmodule

bind sclk_count_guard sclk_count_guard_chk u_chk (
  .clk(clk), .rst(rst), .cs_i(cs_i),
  .permit_o(permit_o), .reject_o(reject_o), .cmd_o(cmd_o)
);

// File: tb/sclk_count_guard_test.sv
module sclk_count_guard_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0, org_i = 1'b0;
  logic permit_o, reject_o;
  logic [1:0] cmd_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_tag = "R1";
  bit seen_p, seen_r;
  logic [1:0] seen_cmd;
  bit fb[$];

  always #2.5 clk = ~clk;

  sclk_count_guard uut (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .org_i(org_i), .permit_o(permit_o), .reject_o(reject_o), .cmd_o(cmd_o)
  );

  // behavioural reference model
  bit m_pcs, m_psck, m_org;
  int m_n;
  bit m_hdr[$];
  bit e_p, e_r;
  logic [1:0] e_cmd;

  always @(posedge clk) begin
    bit np, nr; logic [1:0] nc; int exp_len; bit modf; bit data;
    np = 0; nr = 0; nc = 2'b00; modf = 0; data = 0;
    if (rst) begin
      m_pcs = 0; m_psck = 0; m_n = 0; m_hdr.delete();
    end else begin
      if (m_pcs && !cs_i) begin
        if (m_hdr.size() >= 3 && m_hdr[1] == 0 && m_hdr[2] == 1) begin modf = 1; nc = 2'b00; data = 1; end
        if (m_hdr.size() >= 3 && m_hdr[1] == 1 && m_hdr[2] == 1) begin modf = 1; nc = 2'b01; end
        if (m_hdr.size() >= 5 && m_hdr[1] == 0 && m_hdr[2] == 0) begin
          if (m_hdr[3] == 1 && m_hdr[4] == 0) begin modf = 1; nc = 2'b10; end
          if (m_hdr[3] == 0 && m_hdr[4] == 1) begin modf = 1; nc = 2'b11; data = 1; end
        end
        exp_len = 3 + (m_org ? 8 : 9) + (data ? (m_org ? 16 : 8) : 0);
        if (modf) begin
          np = ((m_n > 63 ? 63 : m_n) == exp_len);
          nr = !np;
        end else nc = 2'b00;
      end
      if (!cs_i) begin
        m_n = 0; m_hdr.delete();
      end else if (sck_i && !m_psck) begin
        if (m_n == 0 && sdi_i) begin m_n = 1; m_hdr.push_back(1'b1); m_org = org_i; end
        else if (m_n > 0) begin
          m_n++;
          if (m_hdr.size() < 5) m_hdr.push_back(sdi_i);
        end
      end
      m_pcs = cs_i; m_psck = sck_i;
    end
    e_p = np; e_r = nr; e_cmd = nc;
  end

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (permit_o !== e_p || reject_o !== e_r || cmd_o !== e_cmd) begin
        bad++;
        $display("FAIL %s cycle compare: got p=%0b r=%0b c=%0d exp p=%0b r=%0b c=%0d",
                 cur_tag, permit_o, reject_o, cmd_o, e_p, e_r, e_cmd);
      end
      if (permit_o) seen_p = 1;
      if (reject_o) seen_r = 1;
      if (permit_o || reject_o) seen_cmd = cmd_o;
    end
  end

  task automatic add(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) fb.push_back(v[i]);
  endtask

  task automatic frame(input logic org, input string tag, input bit ep, input bit er,
                       input logic [1:0] ec, input int flip_at);
    cur_tag = tag; seen_p = 0; seen_r = 0; seen_cmd = 2'b00;
    org_i = org; cs_i = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < fb.size(); i++) begin
      if (i == flip_at) org_i = ~org_i;
      sdi_i = fb[i]; sck_i = 1'b0;
      repeat (2) @(negedge clk);
      sck_i = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck_i = 1'b0;
    repeat (2) @(negedge clk);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    total++;
    if (seen_p !== ep || seen_r !== er || ((ep || er) && seen_cmd !== ec)) begin
      bad++;
      $display("FAIL %s frame: got p=%0b r=%0b c=%0d exp p=%0b r=%0b c=%0d",
               tag, seen_p, seen_r, seen_cmd, ep, er, ec);
    end
    fb.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (permit_o !== 1'b0 || reject_o !== 1'b0 || cmd_o !== 2'b00) begin
      bad++; $display("FAIL R1 reset outputs: got %0b%0b%0d exp 000", permit_o, reject_o, cmd_o);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (permit_o !== 1'b0 || reject_o !== 1'b0) begin
      bad++; $display("FAIL R1 after reset: got %0b%0b exp 00", permit_o, reject_o);
    end
    // R3 write byte 20
    add(1,1); add(1,2); add(9'h0A5,9); add(8'h3C,8); frame(0, "R3", 1, 0, 2'b00, -1);
    // R4 write word 27
    add(1,1); add(1,2); add(8'h5A,8); add(16'hBEEF,16); frame(1, "R4", 1, 0, 2'b00, -1);
    // R5 erase / erase-all
    add(1,1); add(3,2); add(9'h1FF,9); frame(0, "R5", 1, 0, 2'b01, -1);
    add(1,1); add(3,2); add(8'h11,8); frame(1, "R5", 1, 0, 2'b01, -1);
    add(1,1); add(0,2); add(2,2); add(0,7); frame(0, "R5", 1, 0, 2'b10, -1);
    add(1,1); add(0,2); add(2,2); add(0,6); frame(1, "R5", 1, 0, 2'b10, -1);
    // R6 write-all
    add(1,1); add(0,2); add(1,2); add(0,7); add(8'h81,8); frame(0, "R6", 1, 0, 2'b11, -1);
    add(1,1); add(0,2); add(1,2); add(0,6); add(16'h1234,16); frame(1, "R6", 1, 0, 2'b11, -1);
    // R7 mismatches
    add(1,1); add(1,2); add(9'h0A5,9); add(8'h3C,8); add(1,1); frame(0, "R7", 0, 1, 2'b00, -1);
    add(1,1); add(1,2); add(9'h0A5,9); add(8'h3C,7); frame(0, "R7", 0, 1, 2'b00, -1);
    add(1,1); add(1,2); add(8'h5A,8); add(16'hBEEF,16); add(0,1); frame(1, "R7", 0, 1, 2'b00, -1);
    add(1,1); add(3,2); add(8'h11,8); add(0,1); frame(1, "R7", 0, 1, 2'b01, -1);
    add(1,1); add(0,2); add(1,2); add(0,6); add(16'h1234,15); frame(1, "R7", 0, 1, 2'b11, -1);
    // R8 non-modifying and truncated
    add(1,1); add(2,2); add(9'h0A5,9); add(8'h3C,8); frame(0, "R8", 0, 0, 2'b00, -1);
    add(1,1); add(0,2); add(3,2); add(0,7); frame(0, "R8", 0, 0, 2'b00, -1);
    add(1,1); add(0,2); add(0,2); add(0,6); frame(1, "R8", 0, 0, 2'b00, -1);
    add(1,1); add(0,2); add(1,1); frame(0, "R8", 0, 0, 2'b00, -1);
    add(1,1); add(1,1); frame(0, "R8", 0, 0, 2'b00, -1);
    // R2 leading zeros
    add(0,3); add(1,1); add(1,2); add(9'h0A5,9); add(8'h3C,8); frame(0, "R2", 1, 0, 2'b00, -1);
    // R9 saturation: 20 + 64 pulses
    add(1,1); add(1,2); add(9'h0A5,9); add(8'h3C,8);
    for (int k = 0; k < 64; k++) fb.push_back(k[0]);
    frame(0, "R9", 0, 1, 2'b00, -1);
    // R11 clocks while deselected, then org flip mid-frame
    cur_tag = "R11";
    for (int k = 0; k < 5; k++) begin
      sdi_i = 1'b1; sck_i = 1'b1; repeat (2) @(negedge clk);
      sck_i = 1'b0; repeat (2) @(negedge clk);
    end
    add(1,1); add(1,2); add(8'h5A,8); add(16'hBEEF,16); frame(1, "R11", 1, 0, 2'b00, 4);
    add(1,1); add(3,2); add(9'h0F0,9); frame(0, "R11", 1, 0, 2'b01, 2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog %s: got hang exp completion", cur_tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule